// File: doc/BRIEF.md
# Transmit Descriptor Ring Scanner

This block walks a ring of transmit descriptors held in byte-addressed memory and turns every descriptor the host has handed over into a frame on a byte stream. The ring holds a power-of-two number of entries. Each entry takes eight bytes, starting at `ring_base`. Each entry's data buffer sits at `buf_base + index * BUF_BYTES`. A pulse on `kick` starts one pass over the ring. The scanner reads each status byte. For a handed-over entry it reads the 16-bit length, which is stored in negated form, and streams the bytes of the buffer. It then returns the entry to the host by rewriting its status byte.

Memory is reached through one request/grant port that carries one byte per transfer, with one transfer outstanding at a time. Frames leave on a valid/ready byte stream. The stream marks the final byte of each frame. When `pkt_ready` is low the scanner holds its current byte and waits. It has no limit on how long it waits. A control block nearby counts `frame_sent` pulses to raise its transmit-interrupt and summary flags. It reads `busy` to know when a pass has finished.

Top module: `txring_scan`

## Requirements
- R1: After reset, `busy`, `frame_sent`, `mem_req` and `pkt_valid` are low and `ring_ptr` is 0.
- R2: A `kick` seen while idle raises `busy` at the next clock edge. `busy` stays high until the pass ends. A `kick` that arrives while `busy` is high is ignored and does not start another pass.
- R3: A pass visits SIZE-1 entries. It starts at the `ring_ptr` value captured at the kick and steps the visit index by one, modulo SIZE. The entry just before the start is never read or written.
- R4: An entry is sent only when its status byte, at descriptor offset 2, equals exactly 0x83. Any other value is skipped with no further reads and no write.
- R5: The length is read big-endian, with the high byte at descriptor offset 4 and the low byte at offset 5. The byte count is the bitwise inverse of that 16-bit value plus one, modulo 2^16.
- R6: A sent entry streams its byte count of bytes, in address order, from `buf_base + index*BUF_BYTES`. `pkt_last` is high only on the final byte. A count of 0 streams no bytes but the entry is still completed.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_data` and `pkt_last` stay unchanged.
- R8: Each sent entry gets exactly one write, of 0x03 to descriptor offset 2, after its last byte. No other memory write occurs.
- R9: `frame_sent` pulses for one cycle per sent entry, at the clock edge after the status write is granted. `ring_ptr` moves up by one modulo SIZE at that same edge. Skipped entries leave `ring_ptr` unchanged.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle with `mem_gnt` high. Read data is taken from `mem_rdata` in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Starts one pass over the ring when idle |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| buf_base | input | ADDR_W | Byte address of buffer 0 |
| busy | output | 1 | High while a pass is running |
| ring_ptr | output | RING_LOG | Index of the next entry expected to be sent |
| frame_sent | output | 1 | One-cycle pulse per completed frame |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the transfer |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 8 | Read byte, valid the cycle after the grant |
| pkt_valid | output | 1 | Stream byte available |
| pkt_ready | input | 1 | Stream sink takes the byte |
| pkt_data | output | 8 | Stream byte |
| pkt_last | output | 1 | Final byte of the frame |

## Verification
The timing of each result follows from the design. `busy` is high one edge after the kick. A read byte is due on `mem_rdata` one cycle after its grant, and the bench's memory model returns it at the falling edge between those two rising edges. `frame_sent` and the new `ring_ptr` appear at the edge that follows the grant of the status write. The bench therefore samples all of them at falling edges. For each pass it waits for `busy` to fall and then compares the collected stream, the pulse count, the pointer and the memory contents against a model of the pass. Grant and ready are driven from a pseudo-random sequence. A per-cycle watcher counts every request that moves before its grant and every stream byte that changes under back-pressure.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 2;
  localparam int LENH_OFS   = 4;
  localparam int LENL_OFS   = 5;
  localparam int LEN_W      = 16;

  // status byte values: handed over (owned + start + end) and returned
  localparam logic [7:0] ST_READY = 8'h83;
  localparam logic [7:0] ST_DONE  = 8'h03;

  typedef enum logic [3:0] {
    S_IDLE, S_RSTAT, S_WSTAT, S_RLHI, S_WLHI, S_RLLO, S_WLLO,
    S_RBYTE, S_WBYTE, S_PUSH, S_WBACK, S_NEXT
  } st_e;

  typedef enum logic [1:0] {AK_STAT, AK_LENH, AK_LENL, AK_BUF} akind_e;
endpackage

// File: rtl/txr_len.sv
module txr_len
  import txr_pkg::*;
(
  input  logic [7:0]       len_hi,
  input  logic [7:0]       len_lo,
  output logic [LEN_W-1:0] count
);
  logic [LEN_W-1:0] stored;
  assign stored = {len_hi, len_lo};
  // stored value is the negated length; negate it back
  assign count  = ~stored + LEN_W'(1);
endmodule

// File: rtl/txr_addr.sv
module txr_addr
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_LOG  = 2,
  parameter int BUF_BYTES = 64
) (
  input  akind_e              kind,
  input  logic [RING_LOG-1:0] idx,
  input  logic [LEN_W-1:0]    ofs,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic [ADDR_W-1:0]   buf_base,
  output logic [ADDR_W-1:0]   addr
);
  localparam int DESC_SH = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] desc_at;
  logic [ADDR_W-1:0] buf_at;

  assign desc_at = ring_base + (ADDR_W'(idx) << DESC_SH);
  assign buf_at  = buf_base + ADDR_W'(idx) * ADDR_W'(BUF_BYTES);

  always_comb begin
    case (kind)
      AK_LENH: addr = desc_at + ADDR_W'(LENH_OFS);
      AK_LENL: addr = desc_at + ADDR_W'(LENL_OFS);
      AK_BUF:  addr = buf_at + ADDR_W'(ofs);
      default: addr = desc_at + ADDR_W'(STAT_OFS);
    endcase
  end
endmodule

// File: rtl/txr_ptr.sv
module txr_ptr #(
  parameter int RING_LOG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_start,
  input  logic                scan_step,
  input  logic                frame_done,
  output logic [RING_LOG-1:0] ring_ptr,
  output logic [RING_LOG-1:0] scan_idx,
  output logic                scan_last
);
  localparam int SIZE = 1 << RING_LOG;
  localparam logic [RING_LOG-1:0] VISITS = RING_LOG'(SIZE - 1);

  logic [RING_LOG-1:0] left_q;

  // the index width itself is the modulo mask
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_ptr <= '0;
      scan_idx <= '0;
      left_q   <= '0;
    end else begin
      if (frame_done) ring_ptr <= ring_ptr + 1'b1;
      if (scan_start) begin
        scan_idx <= ring_ptr;
        left_q   <= VISITS;
      end else if (scan_step) begin
        scan_idx <= scan_idx + 1'b1;
        left_q   <= left_q - 1'b1;
      end
    end
  end

  assign scan_last = (left_q == RING_LOG'(1));

  // R3: never step past the final visit of a pass
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |-> (left_q > RING_LOG'(1)));
endmodule

// File: rtl/txr_fsm.sv
module txr_fsm
  import txr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic             mem_gnt,
  input  logic [7:0]       mem_rdata,
  output akind_e           kind,
  output logic [LEN_W-1:0] ofs,
  output logic [7:0]       len_hi,
  input  logic [LEN_W-1:0] conv_count,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_data,
  output logic             pkt_last,
  output logic             frame_sent,
  output logic             scan_start,
  output logic             scan_step,
  output logic             frame_done,
  input  logic             scan_last
);
  st_e              st_q, st_d;
  logic [7:0]       lenh_q, data_q;
  logic [LEN_W-1:0] cnt_q, ofs_q;
  logic             last_q, sent_q;

  always_comb begin
    st_d       = st_q;
    scan_start = 1'b0;
    scan_step  = 1'b0;
    case (st_q)
      S_IDLE:  if (kick) begin
                 st_d       = S_RSTAT;
                 scan_start = 1'b1;
               end
      S_RSTAT: if (mem_gnt) st_d = S_WSTAT;
      S_WSTAT: st_d = (mem_rdata == ST_READY) ? S_RLHI : S_NEXT;
      S_RLHI:  if (mem_gnt) st_d = S_WLHI;
      S_WLHI:  st_d = S_RLLO;
      S_RLLO:  if (mem_gnt) st_d = S_WLLO;
      S_WLLO:  st_d = (conv_count == '0) ? S_WBACK : S_RBYTE;
      S_RBYTE: if (mem_gnt) st_d = S_WBYTE;
      S_WBYTE: st_d = S_PUSH;
      S_PUSH:  if (pkt_ready) st_d = last_q ? S_WBACK : S_RBYTE;
      S_WBACK: if (mem_gnt) st_d = S_NEXT;
      S_NEXT:  if (scan_last) st_d = S_IDLE;
               else begin
                 scan_step = 1'b1;
                 st_d      = S_RSTAT;
               end
      default: st_d = S_IDLE;
    endcase
  end

  assign frame_done = (st_q == S_WBACK) && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      lenh_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      ofs_q  <= '0;
      last_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sent_q <= frame_done;
      if (st_q == S_WLHI) lenh_q <= mem_rdata;
      if (st_q == S_WLLO) begin
        cnt_q <= conv_count;
        ofs_q <= '0;
      end
      if (st_q == S_WBYTE) begin
        data_q <= mem_rdata;
        last_q <= ((ofs_q + 1'b1) == cnt_q);
      end
      if (st_q == S_PUSH && pkt_ready) ofs_q <= ofs_q + 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      S_RLHI:  kind = AK_LENH;
      S_RLLO:  kind = AK_LENL;
      S_RBYTE: kind = AK_BUF;
      default: kind = AK_STAT;
    endcase
  end

  assign mem_req    = (st_q == S_RSTAT) || (st_q == S_RLHI) || (st_q == S_RLLO) ||
                      (st_q == S_RBYTE) || (st_q == S_WBACK);
  assign mem_we     = (st_q == S_WBACK);
  assign mem_wdata  = (st_q == S_WBACK) ? ST_DONE : 8'h00;
  assign ofs        = ofs_q;
  assign len_hi     = lenh_q;
  assign busy       = (st_q != S_IDLE);
  assign pkt_valid  = (st_q == S_PUSH);
  assign pkt_data   = data_q;
  assign pkt_last   = last_q;
  assign frame_sent = sent_q;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata) &&
                               $stable(kind) && $stable(ofs)));

  p_pkt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  p_kick_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && kick) |=> busy);

  p_sent_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sent |=> !frame_sent);
endmodule

// File: rtl/txring_scan.sv
module txring_scan
  import txr_pkg::*;
#(
  parameter int RING_LOG  = 2,
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic [ADDR_W-1:0]   buf_base,
  output logic                busy,
  output logic [RING_LOG-1:0] ring_ptr,
  output logic                frame_sent,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic                mem_gnt,
  input  logic [7:0]          mem_rdata,
  output logic                pkt_valid,
  input  logic                pkt_ready,
  output logic [7:0]          pkt_data,
  output logic                pkt_last
);
  akind_e              kind;
  logic [LEN_W-1:0]    ofs, conv_count;
  logic [7:0]          len_hi;
  logic [RING_LOG-1:0] scan_idx;
  logic                scan_start, scan_step, frame_done, scan_last;

  txr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .kind(kind), .ofs(ofs), .len_hi(len_hi), .conv_count(conv_count),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_last(pkt_last), .frame_sent(frame_sent),
    .scan_start(scan_start), .scan_step(scan_step),
    .frame_done(frame_done), .scan_last(scan_last)
  );

  txr_ptr #(.RING_LOG(RING_LOG)) u_ptr (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_step(scan_step),
    .frame_done(frame_done), .ring_ptr(ring_ptr), .scan_idx(scan_idx),
    .scan_last(scan_last)
  );

  txr_addr #(.ADDR_W(ADDR_W), .RING_LOG(RING_LOG), .BUF_BYTES(BUF_BYTES)) u_addr (
    .kind(kind), .idx(scan_idx), .ofs(ofs), .ring_base(ring_base),
    .buf_base(buf_base), .addr(mem_addr)
  );

  // the low length byte is converted as it arrives
  txr_len u_len (
    .len_hi(len_hi), .len_lo(mem_rdata), .count(conv_count)
  );

  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sent |-> (ring_ptr == $past(ring_ptr) + 1'b1));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sent |-> (ring_ptr == $past(ring_ptr)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!pkt_valid && !frame_sent));
endmodule

// File: tb/txring_scan_bench.sv
`timescale 1ns/1ps
module txring_scan_bench;
  localparam int RL = 2;
  localparam int SIZE = 1 << RL;
  localparam int BB = 16;
  localparam int BUFB = 64;
  localparam int MEMSZ = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, kick, busy, frame_sent, mem_req, mem_we, mem_gnt;
  logic pkt_valid, pkt_ready, pkt_last;
  logic [31:0] ring_base, buf_base, mem_addr;
  logic [RL-1:0] ring_ptr;
  logic [7:0] mem_wdata, mem_rdata, pkt_data;

  txring_scan #(.RING_LOG(RL), .ADDR_W(32), .BUF_BYTES(BB)) u_txring_scan (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(ring_base), .buf_base(buf_base),
    .busy(busy), .ring_ptr(ring_ptr), .frame_sent(frame_sent),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last)
  );

  logic [7:0] mem [MEMSZ];
  int total = 0, bad = 0;
  int writes_seen, frames_seen, got_n, req_viol, hold_viol;
  logic [7:0] got_d [256];
  logic got_l [256];
  logic [7:0] exp_d [256];
  logic exp_l [256];
  logic [7:0] st [SIZE];
  logic [7:0] exp_st [SIZE];
  int ln [SIZE];
  bit done_flag = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // memory and sink model, all driven and sampled at falling edges
  initial begin
    logic [15:0] lfsr;
    bit pend, pend_we, prev_req, prev_gnt, prev_we, prev_valid, prev_ready, prev_last;
    logic [6:0] pend_a;
    logic [7:0] pend_wd, prev_wd, prev_data;
    logic [31:0] prev_addr;
    lfsr = 16'hACE1; pend = 0; prev_req = 0; prev_gnt = 0; prev_valid = 0; prev_ready = 0;
    pend_we = 0; pend_a = '0; pend_wd = '0; prev_we = 0; prev_wd = '0; prev_addr = '0;
    prev_data = '0; prev_last = 0;
    mem_gnt = 0; pkt_ready = 0; mem_rdata = '0;
    writes_seen = 0; frames_seen = 0; got_n = 0; req_viol = 0; hold_viol = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        if (pend_we) begin mem[pend_a] = pend_wd; writes_seen++; end
        else mem_rdata = mem[pend_a];
      end
      pend = 0;
      if (rst_n) begin
        if (prev_req && !prev_gnt &&
            !(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd))
          req_viol++;
        if (prev_valid && !prev_ready &&
            !(pkt_valid && pkt_data == prev_data && pkt_last == prev_last))
          hold_viol++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_gnt = mem_req && (lfsr[0] | lfsr[3]);
      if (mem_req && mem_gnt) begin
        pend = 1; pend_a = mem_addr[6:0]; pend_we = mem_we; pend_wd = mem_wdata;
      end
      prev_req = mem_req; prev_gnt = mem_gnt; prev_addr = mem_addr;
      prev_we = mem_we; prev_wd = mem_wdata;
      pkt_ready = lfsr[5] | lfsr[7];
      if (pkt_valid && pkt_ready && got_n < 256) begin
        got_d[got_n] = pkt_data; got_l[got_n] = pkt_last; got_n++;
      end
      prev_valid = pkt_valid; prev_ready = pkt_ready; prev_data = pkt_data; prev_last = pkt_last;
      if (frame_sent) frames_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_ptr;
    logic [7:0] other_st [6];
    other_st[0] = 8'h80; other_st[1] = 8'h82; other_st[2] = 8'h81;
    other_st[3] = 8'h03; other_st[4] = 8'hC3; other_st[5] = 8'h00;
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'h00;
    rst_n = 0; kick = 0; ring_base = 32'd0; buf_base = BUFB;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ring_ptr == 0, "R1 ring_ptr", ring_ptr, 0);
    chk(frame_sent == 0, "R1 frame_sent", frame_sent, 0);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(pkt_valid == 0, "R1 pkt_valid", pkt_valid, 0);
    exp_ptr = 0;

    for (int r = 0; r < 32; r++) begin
      int exp_n, exp_frames, p, n, mism, lmism, skip_i;
      logic [3:0] mask;
      mask = 4'(r) ^ ((r >= 16) ? 4'h6 : 4'h0);
      for (int i = 0; i < SIZE; i++) begin
        logic [15:0] neg;
        st[i] = mask[i] ? 8'h83 : other_st[(i + r) % 6];
        ln[i] = (r * 3 + i * 5) % 17;
        neg = 16'(0 - ln[i]);
        for (int b = 0; b < 8; b++) mem[i*8+b] = 8'h5A;
        mem[i*8+2] = st[i];
        mem[i*8+4] = neg[15:8];
        mem[i*8+5] = neg[7:0];
        for (int k = 0; k < BB; k++) mem[BUFB + i*BB + k] = 8'(r*37 + i*11 + k*7 + 1);
      end
      // model of one pass
      exp_n = 0; exp_frames = 0; p = exp_ptr;
      for (int i = 0; i < SIZE; i++) exp_st[i] = st[i];
      for (int v = 0; v < SIZE - 1; v++) begin
        int i;
        i = (p + v) % SIZE;
        if (st[i] == 8'h83) begin
          for (int k = 0; k < ln[i]; k++) begin
            exp_d[exp_n] = mem[BUFB + i*BB + k];
            exp_l[exp_n] = (k == ln[i] - 1);
            exp_n++;
          end
          exp_frames++;
          exp_st[i] = 8'h03;
        end
      end
      skip_i = (p + SIZE - 1) % SIZE;
      exp_ptr = (exp_ptr + exp_frames) % SIZE;
      got_n = 0; frames_seen = 0; writes_seen = 0; req_viol = 0; hold_viol = 0;

      kick = 1;
      @(negedge clk);
      kick = 0;
      chk(busy == 1, "R2 busy after kick", busy, 1);
      if (r == 9) begin
        repeat (3) @(negedge clk);
        kick = 1;
        @(negedge clk);
        kick = 0;
      end
      n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(busy == 0, "R2 pass ends", busy, 0);
      if (r == 9) begin
        repeat (10) @(negedge clk);
        chk(busy == 0, "R2 kick while busy ignored", busy, 0);
      end
      repeat (2) @(negedge clk);

      chk(got_n == exp_n, "R5 total streamed bytes", got_n, exp_n);
      mism = 0; lmism = 0;
      for (int j = 0; j < exp_n && j < got_n; j++) begin
        if (got_d[j] != exp_d[j]) mism++;
        if (got_l[j] != exp_l[j]) lmism++;
      end
      chk(mism == 0, "R6 stream byte mismatches", mism, 0);
      chk(lmism == 0, "R6 last flag mismatches", lmism, 0);
      chk(frames_seen == exp_frames, "R9 frame_sent pulses", frames_seen, exp_frames);
      chk(ring_ptr == RL'(exp_ptr), "R9 ring_ptr", ring_ptr, exp_ptr);
      chk(writes_seen == exp_frames, "R8 write count", writes_seen, exp_frames);
      for (int i = 0; i < SIZE; i++)
        chk(mem[i*8+2] == exp_st[i], "R4 status byte", mem[i*8+2], exp_st[i]);
      chk(mem[skip_i*8+2] == st[skip_i], "R3 entry before start untouched",
          mem[skip_i*8+2], st[skip_i]);
      chk(req_viol == 0, "R10 request moved before grant", req_viol, 0);
      chk(hold_viol == 0, "R7 stream changed under back-pressure", hold_viol, 0);
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule